// File: doc/BRIEF.md
# UPC-A Serial Symbol Decoder

This block turns a serial stream of barcode modules into the twelve decimal digits of a UPC-A symbol. A one-cycle `start` pulse arms it. After that, each cycle with `bit_valid` high delivers one module on `bit_in`, leftmost module first. When the 95th module has been taken, the block reports whether the symbol was sound. A symbol is sound when the three guard patterns are correct, every 7-module digit group matches a legal code for its half, and the modulo-10 check digit agrees.

Checking runs on the fly. Guard modules are compared as they arrive, and each digit group is looked up on the cycle that completes it. Any fault is held in a sticky flag. The check-digit sum is evaluated once, on the last module. The verdict then appears as a one-cycle `done` pulse. With it comes exactly one of `ok` or `err`, and that flag stays up until the next `start`. A new `start` at any point abandons the symbol being received.

Top module: `upc_stream_decoder`

## Requirements
- R1: After `start`, the block counts only cycles with `bit_valid` high as modules. The `bit_in` value on cycles with `bit_valid` low has no effect on the result. The cycle that carries `start` delivers no module.
- R2: `done` is high for exactly one cycle. That cycle directly follows the clock edge that takes the 95th module after a `start`. Modules delivered while no symbol is armed (no `start` since reset or since the last `done`) produce no `done` and do not change `ok` or `err`.
- R3: In the `done` cycle exactly one of `ok` and `err` is high. Both hold their value until the next `start`, and that `start` drops both on the following cycle.
- R4: Modules 1–3 must be 1,0,1. Modules 46–50 must be 0,1,0,1,0. Modules 93–95 must be 1,0,1. Any mismatch gives `err`.
- R5: Modules 4–45 form six left groups of 7 modules, first-received module as the group's most significant bit. The legal left codes for digits 0 to 9 are 0001101, 0011001, 0010011, 0111101, 0100011, 0110001, 0101111, 0111011, 0110111 and 0001011.
- R6: Modules 51–92 form six right groups. A right group is legal when its bitwise complement is a legal left code, and it decodes to that code's digit.
- R7: A group that is not legal for its half gives `err`. Such a group has the wrong leading or trailing module, the wrong count of ones (odd on the left, even on the right), or no table entry.
- R8: The digit decoded first appears on `digits[11]` and the last on `digits[0]`. All twelve are valid in the `done` cycle when `ok` is high.
- R9: With d1..d12 the digits in received order, 3·(d1+d3+d5+d7+d9+d11) + (d2+d4+d6+d8+d10) + d12 must be a multiple of 10, or the result is `err`.
- R10: A `start` while a symbol is being received discards it: no `done` follows for it, and counting restarts at the first module after that `start`.
- R11: While `rst` is high at a clock edge, `done`, `ok` and `err` go low, all digits go to 0, and the block is left unarmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Arms the decoder for a new symbol; aborts one in progress |
| bit_in | input | 1 | Module value |
| bit_valid | input | 1 | `bit_in` carries a module this cycle |
| digits | output | 12x4 | Decoded BCD digits, [11] first received |
| done | output | 1 | One-cycle end-of-symbol pulse |
| ok | output | 1 | Symbol decoded without fault |
| err | output | 1 | Symbol had a guard, code or check-digit fault |

## Verification
Two events can meet on one clock edge. The first is the closing right-guard comparison on the 95th module, which can itself raise a fault. The second is the check-digit verdict. The bench corrupts the final guard module of an otherwise correct symbol, and it also pairs good guards with a bad check digit. In both cases the single `done` cycle must show `err` alone. A second collision puts a fresh `start` in the same cycle as a valid module in mid-symbol. The per-cycle reference model expects the module to be dropped and the count to restart, and the DUT's `done`, `ok` and `err` are compared against it on every clock.

// File: rtl/upc_pkg.sv
package upc_pkg;

    localparam int FRAME_BITS   = 95;
    localparam int SYM_BITS     = 7;
    localparam int DIGITS       = 12;
    localparam int HALF_DIGITS  = DIGITS / 2;
    localparam int EDGE_LEN     = 3;
    localparam int MID_LEN      = 5;
    localparam int BCD_W        = 4;
    localparam int POS_W        = $clog2(FRAME_BITS);

    localparam int LEFT_START   = EDGE_LEN;
    localparam int MID_START    = LEFT_START + HALF_DIGITS * SYM_BITS;
    localparam int RIGHT_START  = MID_START + MID_LEN;
    localparam int TAIL_START   = RIGHT_START + HALF_DIGITS * SYM_BITS;

    typedef logic [POS_W-1:0]    pos_t;
    typedef logic [BCD_W-1:0]    bcd_t;
    typedef logic [SYM_BITS-1:0] code_t;

    typedef enum logic [2:0] {
        ZN_HEAD,
        ZN_LEFT,
        ZN_MID,
        ZN_RIGHT,
        ZN_TAIL
    } zone_e;

    typedef struct packed {
        logic hit;
        bcd_t value;
    } sym_res_t;

    function automatic zone_e zone_of(pos_t p);
        if (p < pos_t'(LEFT_START))       return ZN_HEAD;
        else if (p < pos_t'(MID_START))   return ZN_LEFT;
        else if (p < pos_t'(RIGHT_START)) return ZN_MID;
        else if (p < pos_t'(TAIL_START))  return ZN_RIGHT;
        else                              return ZN_TAIL;
    endfunction

    // Expected module inside a guard: edges alternate 1,0,1 and the middle 0,1,0,1,0.
    function automatic logic guard_bit(pos_t p);
        int o;
        if (p < pos_t'(LEFT_START))       o = int'(p);
        else if (p < pos_t'(RIGHT_START)) o = int'(p) - MID_START + 1;
        else                              o = int'(p) - TAIL_START;
        return (o % 2) == 0;
    endfunction

    function automatic code_t left_pattern(int d);
        case (d)
            0:       return 7'b0001101;
            1:       return 7'b0011001;
            2:       return 7'b0010011;
            3:       return 7'b0111101;
            4:       return 7'b0100011;
            5:       return 7'b0110001;
            6:       return 7'b0101111;
            7:       return 7'b0111011;
            8:       return 7'b0110111;
            9:       return 7'b0001011;
            default: return '0;
        endcase
    endfunction

    // Right groups are folded to left form first; the left form must carry odd ones.
    function automatic sym_res_t sym_lookup(code_t raw, logic right);
        sym_res_t r;
        code_t    c;
        c       = right ? ~raw : raw;
        r.hit   = 1'b0;
        r.value = '0;
        for (int d = 0; d < 10; d++) begin
            if (c == left_pattern(d)) begin
                r.hit   = 1'b1;
                r.value = bcd_t'(d);
            end
        end
        if (c[0] != 1'b1 || c[SYM_BITS-1] != 1'b0 || (^c) != 1'b1) r.hit = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/upc_frame_ctr.sv
module upc_frame_ctr
    import upc_pkg::*;
#(
    parameter int N_BITS = FRAME_BITS
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic bit_valid,
    output logic take,
    output logic last,
    output pos_t pos
);
    localparam int LAST_POS = N_BITS - 1;

    logic active_q;
    pos_t pos_q;

    assign take = active_q & bit_valid & ~start;
    assign last = take & (pos_q == pos_t'(LAST_POS));
    assign pos  = pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            pos_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            pos_q    <= '0;
        end else if (take) begin
            if (last) begin
                active_q <= 1'b0;
                pos_q    <= '0;
            end else begin
                pos_q <= pos_q + pos_t'(1);
            end
        end
    end
endmodule

// File: rtl/upc_sym_shift.sv
module upc_sym_shift
    import upc_pkg::*;
#(
    parameter int SYM_W = SYM_BITS,
    parameter int N_SYM = DIGITS,
    localparam int SLOT_W = $clog2(N_SYM),
    localparam int PH_W   = $clog2(SYM_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              take,
    input  logic              in_sym,
    input  logic              bit_in,
    output logic              ready,
    output logic [SYM_W-1:0]  code,
    output logic [SLOT_W-1:0] slot
);
    logic [SYM_W-2:0]  sh_q;
    logic [PH_W-1:0]   ph_q;
    logic [SLOT_W-1:0] slot_q;

    assign ready = take & in_sym & (ph_q == PH_W'(SYM_W - 1));
    assign code  = {sh_q, bit_in};
    assign slot  = slot_q;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            sh_q   <= '0;
            ph_q   <= '0;
            slot_q <= '0;
        end else if (take && in_sym) begin
            sh_q <= {sh_q[SYM_W-3:0], bit_in};
            if (ready) begin
                ph_q   <= '0;
                slot_q <= slot_q + SLOT_W'(1);
            end else begin
                ph_q <= ph_q + PH_W'(1);
            end
        end
    end
endmodule

// File: rtl/upc_check_digit.sv
module upc_check_digit
    import upc_pkg::*;
#(
    parameter int N_DIG = DIGITS
) (
    input  logic [N_DIG-1:0][BCD_W-1:0] digs,
    output logic                        good
);
    int acc;

    // Index N_DIG-1 is the first digit received; odd indices take weight three.
    always_comb begin
        acc = 0;
        for (int i = 0; i < N_DIG; i++) begin
            acc = acc + (((i % 2) == 1) ? 3 : 1) * int'(digs[i]);
        end
    end

    assign good = (acc % 10) == 0;
endmodule

// File: rtl/upc_stream_decoder.sv
module upc_stream_decoder
    import upc_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic                         bit_in,
    input  logic                         bit_valid,
    output logic [DIGITS-1:0][BCD_W-1:0] digits,
    output logic                         done,
    output logic                         ok,
    output logic                         err
);
    localparam int SLOT_W = $clog2(DIGITS);

    logic              take, last, sym_ready, in_sym, is_guard;
    logic              guard_miss, sym_miss, sum_good, bad;
    pos_t              pos;
    zone_e             zone;
    code_t             code;
    logic [SLOT_W-1:0] slot, dig_idx;
    sym_res_t          res;

    logic                         fault_q, done_q, ok_q, err_q;
    logic [DIGITS-1:0][BCD_W-1:0] digits_q;

    upc_frame_ctr #(.N_BITS(FRAME_BITS)) u_frame (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .bit_valid(bit_valid),
        .take     (take),
        .last     (last),
        .pos      (pos)
    );

    assign zone     = zone_of(pos);
    assign in_sym   = (zone == ZN_LEFT) || (zone == ZN_RIGHT);
    assign is_guard = ~in_sym;

    upc_sym_shift #(.SYM_W(SYM_BITS), .N_SYM(DIGITS)) u_sym (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .take  (take),
        .in_sym(in_sym),
        .bit_in(bit_in),
        .ready (sym_ready),
        .code  (code),
        .slot  (slot)
    );

    assign res        = sym_lookup(code, zone == ZN_RIGHT);
    assign guard_miss = take & is_guard & (bit_in != guard_bit(pos));
    assign sym_miss   = sym_ready & ~res.hit;
    assign dig_idx    = SLOT_W'(DIGITS - 1) - slot;

    upc_check_digit #(.N_DIG(DIGITS)) u_sum (
        .digs(digits_q),
        .good(sum_good)
    );

    // The final module is a guard module, so its own comparison joins the verdict here.
    assign bad = fault_q | guard_miss | ~sum_good;

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q  <= 1'b0;
            digits_q <= '0;
        end else if (start) begin
            fault_q <= 1'b0;
        end else begin
            if (guard_miss || sym_miss) fault_q <= 1'b1;
            if (sym_ready) digits_q[dig_idx] <= res.value;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            ok_q   <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= last;
            if (start) begin
                ok_q  <= 1'b0;
                err_q <= 1'b0;
            end else if (last) begin
                ok_q  <= ~bad;
                err_q <= bad;
            end
        end
    end

    assign digits = digits_q;
    assign done   = done_q;
    assign ok     = ok_q;
    assign err    = err_q;
endmodule

// File: rtl/upc_stream_decoder_chk.sv
module upc_stream_decoder_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic done,
    input logic ok,
    input logic err
);
    p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        !(ok && err));

    p_done_has_verdict_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> (ok != err));

    p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_start_clears_r3: assert property (@(posedge clk) disable iff (rst)
        start |=> (!ok && !err));

    p_start_no_done_r10: assert property (@(posedge clk) disable iff (rst)
        start |=> !done);

    p_ok_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (ok && !start) |=> ok);

    p_err_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (err && !start) |=> err);

    p_reset_idle_r11: assert property (@(posedge clk)
        rst |=> (!done && !ok && !err));
endmodule

bind upc_stream_decoder upc_stream_decoder_chk chk_i (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .done (done),
    .ok   (ok),
    .err  (err)
);

// File: tb/upc_stream_decoder_tb_top.sv
module upc_stream_decoder_tb_top;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, bit_in = 1'b0, bit_valid = 1'b0;
    logic [11:0][3:0] digits;
    logic done, ok, err;

    always #2 clk = ~clk;

    upc_stream_decoder dut_i (
        .clk(clk), .rst(rst), .start(start), .bit_in(bit_in),
        .bit_valid(bit_valid), .digits(digits), .done(done), .ok(ok), .err(err)
    );

    int    vectors = 0;
    int    misses  = 0;
    string cur_req = "R11";

    function automatic logic [6:0] lcode(int d);
        case (d)
            0: return 7'b0001101;  1: return 7'b0011001;
            2: return 7'b0010011;  3: return 7'b0111101;
            4: return 7'b0100011;  5: return 7'b0110001;
            6: return 7'b0101111;  7: return 7'b0111011;
            8: return 7'b0110111;  default: return 7'b0001011;
        endcase
    endfunction

    function automatic logic [94:0] build(logic [11:0][3:0] d);
        logic [94:0] f;
        int p = 94;
        logic [2:0] edge_g = 3'b101;
        logic [4:0] mid_g  = 5'b01010;
        logic [6:0] c;
        for (int j = 2; j >= 0; j--) begin f[p] = edge_g[j]; p--; end
        for (int k = 11; k >= 6; k--) begin
            c = lcode(int'(d[k]));
            for (int j = 6; j >= 0; j--) begin f[p] = c[j]; p--; end
        end
        for (int j = 4; j >= 0; j--) begin f[p] = mid_g[j]; p--; end
        for (int k = 5; k >= 0; k--) begin
            c = ~lcode(int'(d[k]));
            for (int j = 6; j >= 0; j--) begin f[p] = c[j]; p--; end
        end
        for (int j = 2; j >= 0; j--) begin f[p] = edge_g[j]; p--; end
        return f;
    endfunction

    function automatic logic [3:0] fix_check(logic [11:0][3:0] d);
        int s = 0;
        for (int i = 1; i < 12; i++) s += (((i % 2) == 1) ? 3 : 1) * int'(d[i]);
        return 4'((10 - (s % 10)) % 10);
    endfunction

    // ---------------- behavioural reference model ----------------
    bit q[$];
    bit m_active = 0, m_done = 0, m_ok = 0, m_err = 0;
    logic [11:0][3:0] m_digits = '0;

    task automatic judge();
        bit fault = 0;
        int s = 0;
        logic [6:0] c;
        bit found;
        bit [2:0] eg = 3'b101;
        bit [4:0] mg = 5'b01010;
        for (int j = 0; j < 3; j++) begin
            if (q[j] != eg[2-j]) fault = 1;
            if (q[92+j] != eg[2-j]) fault = 1;
        end
        for (int j = 0; j < 5; j++) if (q[45+j] != mg[4-j]) fault = 1;
        for (int k = 0; k < 12; k++) begin
            int base = (k < 6) ? 3 + 7*k : 50 + 7*(k-6);
            for (int j = 0; j < 7; j++) c[6-j] = q[base+j];
            if (k >= 6) c = ~c;
            found = 0;
            for (int d = 0; d < 10; d++) if (c == lcode(d)) begin found = 1; m_digits[11-k] = 4'(d); end
            if (!found) fault = 1;
        end
        for (int i = 0; i < 12; i++) s += (((i % 2) == 1) ? 3 : 1) * int'(m_digits[i]);
        if (s % 10 != 0) fault = 1;
        m_ok  = !fault;
        m_err = fault;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            q.delete(); m_active = 0; m_done = 0; m_ok = 0; m_err = 0;
        end else begin
            m_done = 0;
            if (start) begin
                q.delete(); m_active = 1; m_ok = 0; m_err = 0;
            end else if (m_active && bit_valid) begin
                q.push_back(bit_in);
                if (q.size() == 95) begin
                    judge(); m_done = 1; m_active = 0;
                end
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        vectors++;
        if (done !== m_done || ok !== m_ok || err !== m_err) begin
            misses++;
            $display("FAIL %s done/ok/err actual=%b%b%b expected=%b%b%b at %0t",
                     cur_req, done, ok, err, m_done, m_ok, m_err, $time);
        end
        if (m_done && m_ok) begin
            vectors++;
            if (digits !== m_digits) begin
                misses++;
                $display("FAIL R8 digits actual=%h expected=%h", digits, m_digits);
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        misses++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        summary();
    end

    task automatic idle(int n);
        repeat (n) begin @(negedge clk); start = 0; bit_valid = 0; end
    endtask

    task automatic send_frame(logic [94:0] f, int gap);
        @(negedge clk); start = 1; bit_valid = 0;
        for (int i = 94; i >= 0; i--) begin
            @(negedge clk); start = 0;
            if (gap != 0 && (i % gap) == 0) begin
                bit_valid = 0; bit_in = ~f[i];   // R1: junk on an invalid cycle
                @(negedge clk);
            end
            bit_valid = 1; bit_in = f[i];
        end
        @(negedge clk); bit_valid = 0;
        idle(3);
    endtask

    logic [11:0][3:0] dv;
    logic [94:0]      fr;

    initial begin
        // R11: reset state
        idle(3);
        vectors++;
        if (digits !== '0 || done !== 0 || ok !== 0 || err !== 0) begin
            misses++;
            $display("FAIL R11 reset actual=%h/%b%b%b expected=0/000", digits, done, ok, err);
        end
        rst = 0;
        idle(2);

        // R5 R6 R8: known good symbol 0 36000 29145 2
        cur_req = "R8";
        dv = {4'd0,4'd3,4'd6,4'd0,4'd0,4'd0,4'd2,4'd9,4'd1,4'd4,4'd5,4'd2};
        send_frame(build(dv), 0);

        // R1: same symbol with idle gaps carrying junk
        cur_req = "R1";
        send_frame(build(dv), 5);

        // R9: generated symbols with computed check digit
        cur_req = "R9";
        for (int n = 0; n < 4; n++) begin
            for (int i = 1; i < 12; i++) dv[i] = 4'((i * 7 + n * 3 + i * n) % 10);
            dv[0] = fix_check(dv);
            send_frame(build(dv), (n == 2) ? 3 : 0);
            dv[0] = 4'((int'(dv[0]) + 1 + n) % 10);   // R9: wrong check digit
            send_frame(build(dv), 0);
        end

        // R4: guard faults, last one coincides with the verdict cycle
        cur_req = "R4";
        dv = {4'd0,4'd3,4'd6,4'd0,4'd0,4'd0,4'd2,4'd9,4'd1,4'd4,4'd5,4'd2};
        fr = build(dv); fr[94-1]  = ~fr[94-1];  send_frame(fr, 0);
        fr = build(dv); fr[94-47] = ~fr[94-47]; send_frame(fr, 0);
        fr = build(dv); fr[0]     = ~fr[0];     send_frame(fr, 0);

        // R7: corrupted groups in each half
        cur_req = "R7";
        fr = build(dv); fr[94-10] = ~fr[94-10]; send_frame(fr, 0);
        fr = build(dv); fr[94-60] = ~fr[94-60]; send_frame(fr, 0);

        // R6: right group sent in left (uninverted) form
        cur_req = "R6";
        fr = build(dv); fr[94-50 -: 7] = lcode(5); send_frame(fr, 0);

        // R10: abort mid-symbol, then a full symbol; also start beside a valid module
        cur_req = "R10";
        fr = build(dv);
        @(negedge clk); start = 1;
        for (int i = 94; i > 54; i--) begin @(negedge clk); start = 0; bit_valid = 1; bit_in = fr[i]; end
        @(negedge clk); start = 1; bit_valid = 1; bit_in = 1;
        @(negedge clk); start = 0; bit_valid = 0;
        for (int i = 94; i >= 0; i--) begin bit_valid = 1; bit_in = fr[i]; @(negedge clk); end
        bit_valid = 0;
        idle(3);

        // R2: modules without start give no done
        cur_req = "R2";
        for (int i = 94; i >= 0; i--) begin @(negedge clk); bit_valid = 1; bit_in = fr[i]; end
        idle(4);

        // R3: flags hold while idle, then a bare start clears them
        cur_req = "R3";
        idle(6);
        @(negedge clk); start = 1;
        idle(3);

        summary();
    end
endmodule